// File: doc/BRIEF.md
# Cascadable Configuration Stream Reader

This block is the read side of a one-time-programmed store that holds a bitstream for a downstream loader. A consumer supplies the clock and a chip enable. On every rising edge where the enable is high, the block steps through its stored contents. It presents the next item either as one bit per clock or as a full byte per clock. At the same clock rate the byte-wide form carries eight times the data of the serial form. Each item becomes visible a short time after the rising edge that selects it, and the consumer captures it on the following rising edge.

Several readers can share one set of data lines. Each reader's chain-enable output is wired to the enable input of the next reader. When a reader has presented its last item, it stops driving and raises its chain-enable output, and the next reader takes over the lines with its own first item. The data pads are controlled by an output value vector and a per-line drive-enable vector. A line whose enable is low is in high impedance. The consumer ends the transfer by lowering the enable, and from then on no reader drives.

Reset polarity is set by a strap input. The output mode is captured while reset is active and kept fixed after that. Reset takes effect asynchronously. Its release is synchronised, and reading can begin from the second rising edge after reset is released. The store holds DEPTH bytes, a power of two. The full-size part is 2 Mi bytes (16 Mbit), and a small depth is used for simulation. The stored pattern is computed from two parameters.

Top module: `cfg_stream_reader`

## Requirements
- R1: Reset is active while rst_i equals rst_pol_i (rst_pol_i=1: active high; rst_pol_i=0: active low). While reset is active, data_en_o is 8'h00 and ceo_o is 0 whatever ce_i is. After release, reading starts at item 0.
- R2: Stored byte k equals (k*PAT_MUL + PAT_ADD) mod 256. The defaults are PAT_MUL=37 and PAT_ADD=8'h5A.
- R3: Byte mode is mode_i=1 at reset. In this mode data_o carries stored byte k and data_en_o is 8'hFF. Each rising edge with ce_i high moves k to k+1, and the new value is visible after that edge.
- R4: Serial mode is mode_i=0 at reset. Stream bit j is bit (7 - j mod 8) of byte j/8, so each byte goes out most significant bit first. The bit appears on data_o[0], with data_o[7:1]=0 and data_en_o=8'h01.
- R5: While ce_i is low, data_en_o is 8'h00 and ceo_o is 0, and the read position is held. Raising ce_i again resumes at the same item.
- R6: The rising edge that consumes the last item (DEPTH-1 in byte mode, DEPTH*8-1 in serial mode) exhausts the device. From then until the next reset, data_en_o is 8'h00, ceo_o equals ce_i, and the position no longer changes.
- R7: A change of mode_i outside reset has no effect on the output format or on the item count.
- R8: When a device's ceo_o drives the next device's ce_i, no two devices enable their lines at the same time. The next device's item 0 appears right after the previous device's last item.
- R9: A reset during a transfer restarts the stream at item 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Read clock from the consumer |
| rst_i | input | 1 | Reset, active level set by rst_pol_i |
| rst_pol_i | input | 1 | Static strap: 1 makes reset active high, 0 active low |
| mode_i | input | 1 | Output format captured in reset: 1 byte-wide, 0 serial |
| ce_i | input | 1 | Chip enable from the consumer or the previous device |
| data_o | output | 8 | Data value towards the pads |
| data_en_o | output | 8 | Per-line pad drive enable; 0 means high impedance |
| ceo_o | output | 1 | Chain enable towards the next device |

## Verification
On every clock, the embedded properties check several things. The read position holds while the enable is low and otherwise steps by exactly one. Once exhaustion is reached it is permanent. The position never passes the last item of the captured mode, and the captured mode stays fixed outside reset. No reader drives its lines while its chain-enable is high, and the serial lane uses only line 0. Other behaviour can only be shown by the bench's scenarios. These include the stored values and the bit order, a seamless handover to a second device on a shared bus, resuming after a pause, ignoring a mode change during a transfer, both reset polarities, and a restart after a reset in mid-stream.

// File: rtl/cfgrd_pkg.sv
package cfgrd_pkg;

  localparam int unsigned BYTE_W = 8;

  typedef enum logic {
    MODE_SERIAL = 1'b0,
    MODE_BYTE   = 1'b1
  } rd_mode_e;

  // Content of stored byte idx: linear pattern, wrapping at 256.
  function automatic logic [BYTE_W-1:0] pattern_byte(input int unsigned idx,
                                                     input int unsigned mul,
                                                     input int unsigned add);
    return BYTE_W'(idx * mul + add);
  endfunction

endpackage

// File: rtl/cfgrd_rst.sv
// Reset with strap-selected polarity: asserts asynchronously,
// releases through a synchroniser.
module cfgrd_rst #(
  parameter int unsigned SYNC_STAGES = 2  // must be 2 or more
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic rst_pol_i,
  output logic rst_n_o
);

  logic                   arst_n;
  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_d;

  // Reset active when the pin matches the strapped level.
  assign arst_n = rst_i ^ rst_pol_i;

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_o = sync_q[SYNC_STAGES-1];

endmodule

// File: rtl/cfgrd_ctr.sv
// Read-position counter, exhaustion flag and captured mode.
module cfgrd_ctr
  import cfgrd_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned AW    = $clog2(DEPTH * BYTE_W)
) (
  input  logic          clk_i,
  input  logic          rst_n_i,
  input  logic          ce_i,
  input  logic          mode_i,
  output logic [AW-1:0] addr_o,
  output logic          done_o,
  output rd_mode_e      mode_o
);

  localparam int unsigned BITS = DEPTH * BYTE_W;
  localparam logic [AW-1:0] LAST_BYTE = AW'(DEPTH - 1);
  localparam logic [AW-1:0] LAST_BIT  = AW'(BITS - 1);

  logic [AW-1:0] addr_q, addr_d;
  logic          done_q, done_d;
  logic          step;
  logic [AW-1:0] last;
  rd_mode_e      mode_q;

  // Mode is sampled on every clock during reset and then frozen.
  always_ff @(posedge clk_i) begin
    if (!rst_n_i) begin
      mode_q <= rd_mode_e'(mode_i);
    end
  end

  always_comb begin
    last   = (mode_q == MODE_BYTE) ? LAST_BYTE : LAST_BIT;
    step   = ce_i && !done_q;
    addr_d = addr_q;
    done_d = done_q;
    if (addr_q == last) begin
      done_d = 1'b1;
    end else begin
      addr_d = addr_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      addr_q <= '0;
      done_q <= 1'b0;
    end else if (step) begin
      addr_q <= addr_d;
      done_q <= done_d;
    end
  end

  assign addr_o = addr_q;
  assign done_o = done_q;
  assign mode_o = mode_q;

  // R1: position starts at zero when reset is released
  p_start_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $rose(rst_n_i) |-> (addr_q == '0 && !done_q));

  // R5: enable low freezes the position
  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !ce_i |=> $stable(addr_q) && $stable(done_q));

  // R3: enabled and not exhausted: advance by one or exhaust
  p_advance_r3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (ce_i && !done_q) |=> (done_q || addr_q == AW'($past(addr_q) + 1'b1)));

  // R6: exhaustion is permanent until reset
  p_done_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    done_q |=> (done_q && $stable(addr_q)));

  // R6: position never runs past the last item
  p_no_overflow_r6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    addr_q <= last);

  // R7: captured mode is constant outside reset
  p_mode_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $past(rst_n_i) |-> $stable(mode_q));

endmodule

// File: rtl/cfgrd_out.sv
// Pattern store and output lane formatting with pad drive enables.
module cfgrd_out
  import cfgrd_pkg::*;
#(
  parameter int unsigned DEPTH   = 16,
  parameter int unsigned PAT_MUL = 37,
  parameter int unsigned PAT_ADD = 8'h5A,
  parameter int unsigned AW      = $clog2(DEPTH * BYTE_W)
) (
  input  logic [AW-1:0]     addr_i,
  input  rd_mode_e          mode_i,
  input  logic              active_i,
  output logic [BYTE_W-1:0] data_o,
  output logic [BYTE_W-1:0] data_en_o
);

  localparam int unsigned BW = $clog2(DEPTH);

  logic [BYTE_W-1:0] mem [DEPTH];
  logic [BW-1:0]     byte_idx;
  logic [2:0]        bit_sel;
  logic [BYTE_W-1:0] cur_byte;

  for (genvar g = 0; g < DEPTH; g++) begin : g_store
    assign mem[g] = pattern_byte(g, PAT_MUL, PAT_ADD);
  end

  always_comb begin
    byte_idx = (mode_i == MODE_BYTE) ? addr_i[BW-1:0] : addr_i[AW-1:3];
    bit_sel  = 3'd7 - addr_i[2:0];
    cur_byte = mem[byte_idx];
    data_o    = '0;
    data_en_o = '0;
    if (active_i) begin
      if (mode_i == MODE_BYTE) begin
        data_o    = cur_byte;
        data_en_o = '1;
      end else begin
        data_o[0]    = cur_byte[bit_sel];
        data_en_o[0] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/cfg_stream_reader.sv
module cfg_stream_reader
  import cfgrd_pkg::*;
#(
  parameter int unsigned DEPTH       = 16,
  parameter int unsigned PAT_MUL     = 37,
  parameter int unsigned PAT_ADD     = 8'h5A,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              rst_pol_i,
  input  logic              mode_i,
  input  logic              ce_i,
  output logic [BYTE_W-1:0] data_o,
  output logic [BYTE_W-1:0] data_en_o,
  output logic              ceo_o
);

  localparam int unsigned AW = $clog2(DEPTH * BYTE_W);

  logic          rst_n;
  logic [AW-1:0] addr;
  logic          done;
  rd_mode_e      mode;
  logic          active;

  cfgrd_rst #(.SYNC_STAGES(SYNC_STAGES)) u_rst (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .rst_pol_i (rst_pol_i),
    .rst_n_o   (rst_n)
  );

  cfgrd_ctr #(.DEPTH(DEPTH), .AW(AW)) u_ctr (
    .clk_i   (clk_i),
    .rst_n_i (rst_n),
    .ce_i    (ce_i),
    .mode_i  (mode_i),
    .addr_o  (addr),
    .done_o  (done),
    .mode_o  (mode)
  );

  assign active = rst_n && ce_i && !done;

  cfgrd_out #(.DEPTH(DEPTH), .PAT_MUL(PAT_MUL), .PAT_ADD(PAT_ADD), .AW(AW)) u_out (
    .addr_i    (addr),
    .mode_i    (mode),
    .active_i  (active),
    .data_o    (data_o),
    .data_en_o (data_en_o)
  );

  assign ceo_o = rst_n && done && ce_i;

  // R8: never drive the lines while handing over to the next device
  p_no_overlap_r8: assert property (@(posedge clk_i) disable iff (!rst_n)
    !((|data_en_o) && ceo_o));

  // R4: serial format uses line 0 only
  p_serial_lane_r4: assert property (@(posedge clk_i) disable iff (!rst_n)
    (mode == MODE_SERIAL) |-> (data_en_o[BYTE_W-1:1] == '0 && data_o[BYTE_W-1:1] == '0));

endmodule

// File: tb/cfg_stream_reader_tb.sv
module cfg_stream_reader_tb;

  localparam int unsigned DEPTH = 16;
  localparam int unsigned MUL   = 37;
  localparam int unsigned ADD_A = 8'h5A;
  localparam int unsigned ADD_B = 8'hC3;

  logic       clk = 1'b0;
  logic       rst_i, rst_pol_i, mode_i, ce_i;
  logic [7:0] d1, e1, d2, e2, bus;
  logic       c1, c2;
  int         n_cmp = 0;
  int         n_bad = 0;

  always #5 clk = ~clk;

  cfg_stream_reader #(.DEPTH(DEPTH), .PAT_MUL(MUL), .PAT_ADD(ADD_A)) u_dut (
    .clk_i(clk), .rst_i(rst_i), .rst_pol_i(rst_pol_i), .mode_i(mode_i),
    .ce_i(ce_i), .data_o(d1), .data_en_o(e1), .ceo_o(c1));

  cfg_stream_reader #(.DEPTH(DEPTH), .PAT_MUL(MUL), .PAT_ADD(ADD_B)) u_nxt (
    .clk_i(clk), .rst_i(rst_i), .rst_pol_i(rst_pol_i), .mode_i(mode_i),
    .ce_i(c1), .data_o(d2), .data_en_o(e2), .ceo_o(c2));

  // Shared bus as resolved by the pads.
  assign bus = (d1 & e1) | (d2 & e2);

  function automatic logic [7:0] exp_byte(input int dev, input int k);
    int v;
    v = k * MUL + ((dev == 0) ? ADD_A : ADD_B);
    return v[7:0];
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare bus, own enables and the other device's enables for item idx.
  task automatic expect_item(input int dev, input bit bmode, input int idx,
                             input string tag);
    logic [7:0] xd, xe, own_e, oth_e, b;
    if (bmode) begin
      xd = exp_byte(dev, idx);
      xe = 8'hFF;
    end else begin
      b  = exp_byte(dev, idx / 8);
      xd = {7'b0, b[7 - (idx % 8)]};
      xe = 8'h01;
    end
    own_e = (dev == 0) ? e1 : e2;
    oth_e = (dev == 0) ? e2 : e1;
    chk(bus == xd, {tag, " data"}, 32'(bus), 32'(xd));
    chk(own_e == xe, {tag, " enable"}, 32'(own_e), 32'(xe));
    chk(oth_e == 8'h00, {tag, " other idle"}, 32'(oth_e), 32'h0);
  endtask

  // Enter reset at the given polarity with CE high; check quiet outputs (R1).
  task automatic do_reset(input bit pol, input bit bmode);
    @(negedge clk);
    rst_pol_i = pol;
    rst_i     = pol;
    mode_i    = bmode;
    ce_i      = 1'b1;
    #2;
    chk(e1 == 8'h00 && e2 == 8'h00, "R1 enables in reset", 32'({e1, e2}), 32'h0);
    chk(c1 == 1'b0 && c2 == 1'b0, "R1 chain out in reset", 32'({c1, c2}), 32'h0);
    repeat (3) @(negedge clk);
    rst_i = ~pol;
    ce_i  = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog R1 actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_pol_i = 1'b0;
    rst_i     = 1'b0;
    mode_i    = 1'b1;
    ce_i      = 1'b0;

    // Byte mode, active-low reset, two-device chain (R2 R3 R8 R6).
    do_reset(1'b0, 1'b1);
    ce_i = 1'b1;
    for (int k = 0; k < DEPTH; k++) begin
      #2 expect_item(0, 1'b1, k, "R2 R3 byte");
      @(negedge clk);
    end
    #2 chk(c1 == 1'b1, "R6 chain out after last byte", 32'(c1), 32'h1);
    for (int k = 0; k < DEPTH; k++) begin
      #2 expect_item(1, 1'b1, k, "R8 next device byte");
      @(negedge clk);
    end
    #2 chk(c2 == 1'b1 && e1 == 8'h00 && e2 == 8'h00, "R6 both exhausted",
           32'({c2, e1, e2}), 32'h10000);
    repeat (3) @(negedge clk);
    #2 chk(c1 == 1'b1 && e1 == 8'h00, "R6 stays exhausted", 32'({c1, e1}), 32'h100);
    @(negedge clk);
    ce_i = 1'b0;
    #2 chk(c1 == 1'b0 && c2 == 1'b0, "R6 chain out follows ce", 32'({c1, c2}), 32'h0);

    // Serial mode, active-high reset, with a pause (R4 R5 R8).
    do_reset(1'b1, 1'b0);
    ce_i = 1'b1;
    for (int j = 0; j < DEPTH * 8; j++) begin
      if (j == 40) begin
        ce_i = 1'b0;
        #2;
        chk(e1 == 8'h00 && c1 == 1'b0, "R5 paused outputs", 32'({e1, c1}), 32'h0);
        repeat (3) @(negedge clk);
        ce_i = 1'b1;
      end
      #2 expect_item(0, 1'b0, j, "R4 serial bit");
      @(negedge clk);
    end
    for (int j = 0; j < 16; j++) begin
      #2 expect_item(1, 1'b0, j, "R8 next device serial");
      @(negedge clk);
    end

    // Mode change outside reset is ignored (R7).
    do_reset(1'b1, 1'b1);
    ce_i = 1'b1;
    for (int k = 0; k < DEPTH; k++) begin
      if (k == 5) mode_i = 1'b0;
      #2 expect_item(0, 1'b1, k, "R7 byte format kept");
      @(negedge clk);
    end
    #2 chk(c1 == 1'b1, "R7 byte count kept", 32'(c1), 32'h1);

    // Reset in mid-stream restarts at item 0 (R9).
    do_reset(1'b0, 1'b1);
    ce_i = 1'b1;
    for (int k = 0; k < 7; k++) begin
      #2 expect_item(0, 1'b1, k, "R3 byte before restart");
      @(negedge clk);
    end
    do_reset(1'b0, 1'b1);
    ce_i = 1'b1;
    for (int k = 0; k < 4; k++) begin
      #2 expect_item(0, 1'b1, k, "R9 restart");
      @(negedge clk);
    end

    finish_run();
  end

endmodule